// File: doc/BRIEF.md
# Compound Frame List Walker

This block turns one job description held in memory into a decoded job for an execution unit. A job is described by a list of 16-byte frame entries. Each entry carries a 64-bit buffer address, a length and a "last entry" flag. The first entry points at a one-word command block. The entries that follow name the destination buffers and then the source buffers. The walker fetches entries one word at a time through a request/response memory port and stops at the entry whose last flag is set. It then presents the job on a valid/ready output: the opcode, flags, common length, destination addresses and source addresses, together with a status code. It moves no data itself.

The role of each entry is set by its position and by the opcode. A move or XOR job has one destination. A dual-parity job has two destinations. The list length is never given explicitly: the walker relies on the last flag, then checks the number of sources it saw against the count in the command word.

Back-pressure rules:
- Start channel: `start_valid` is accepted in any cycle in which `start_ready` is high. `start_ready` is high only while the walker is idle.
- Request channel: once `mem_req_valid` is raised, the request and its address are held until `mem_req_ready` is seen.
- Response channel: exactly one word is expected for each accepted request, and only one request is outstanding at any time. Responses have no ready signal.
- Job channel: once `job_valid` is raised, every job output holds steady until `job_ready` is seen.

Top module: `cfdw_walker`

## Requirements
- R1: After reset `start_ready` is 1 and both `job_valid` and `mem_req_valid` are 0. A start is accepted only while idle, and `start_ready` stays low from acceptance until the job is taken.
- R2: Frame entry k is read as three words at byte addresses base+16k, base+16k+4 and base+16k+8. After entry 0 the command word is read from entry 0's buffer address. One request at a time is outstanding, so a job whose list holds E walked entries costs exactly 3E+1 requests. A request stalled by `mem_req_ready` keeps its address.
- R3: In entry word 0, bits [23:0] hold the length and bit 30 is the last flag. Word 1 is the high half of the address and word 2 is the low half.
- R4: In the command word:
  - bits [1:0] are the opcode: 1 move, 2 XOR parity, 3 dual P/Q parity, 0 invalid;
  - bits [7:4] hold the source count minus one;
  - bits [10:8] hold the block-size code;
  - bit 12 is the interrupt-on-error flag;
  - bit 13 is the data-dependency flag.
  
  These fields appear unchanged on the job port.
- R5: For move and XOR jobs, entry 1 is destination slot 0. For P/Q jobs, entries 1 and 2 are destination slots 0 and 1. All later entries are sources, stored in list order from source slot 0.
- R6: The walk ends at the first entry with the last flag set. If no such flag appears within MAX_SRC+3 entries, the job is reported malformed after exactly MAX_SRC+3 entries have been read.
- R7: A job is malformed (status 1) in any of these cases:
  - the opcode is 0, in which case the walk stops right after the command word;
  - entry 0 carries the last flag;
  - the number of sources seen differs from the command count;
  - the number of sources exceeds MAX_SRC;
  - a move job has a source count other than one.
- R8: A destination or source length above 1 MiB (0x100000), or a length that differs from entry 1's length, gives status 2. A malformed job reports 1 even when it also has a length fault, and a clean job reports 0. The reported length is entry 1's length.
- R9: Job outputs hold steady while `job_valid` is high and `job_ready` is low. The cycle after `job_ready` is seen, the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Walker idle, start accepted |
| start_addr | input | ADDR_W | Byte address of entry 0 |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Word byte address |
| mem_rsp_valid | input | 1 | Read word returned |
| mem_rsp_data | input | 32 | Read word |
| job_valid | output | 1 | Decoded job present |
| job_ready | input | 1 | Execution unit takes job |
| job_status | output | 2 | 0 ok, 1 malformed, 2 length fault |
| job_opcode | output | 2 | Decoded opcode |
| job_nsrc | output | 5 | Sources seen |
| job_blk | output | 3 | Block-size code |
| job_irq_err | output | 1 | Interrupt-on-error flag |
| job_dep | output | 1 | Data-dependency flag |
| job_len | output | 24 | Common buffer length |
| job_dst_addr | output | 2*ADDR_W | Destination slots, slot i at bits i*ADDR_W |
| job_src_addr | output | MAX_SRC*ADDR_W | Source slots, slot i at bits i*ADDR_W |

## Verification
The bench builds the walker with MAX_SRC=4 and ADDR_W=64, so the entry limit is only seven. This lets it sweep every opcode against every source count from zero to one past capacity. The sweep runs once with a matching command count and once with a wrong one. Those two runs reach the overrun path, the capacity check and the move single-source rule in a few hundred cycles each. Further cases cover the invalid opcode, the missing last flag, the exact 1 MiB length, one byte over it, and a length mismatch with and without a count fault. The memory model also alternates its ready and response latency, so stalled requests are covered too.

// File: rtl/cfdw_pkg.sv
package cfdw_pkg;
  localparam int LEN_W      = 24;
  localparam int LAST_BIT   = 30;
  localparam int LEN_LIMIT  = 1 << 20;
  localparam int CNT_W      = 5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MOVE = 2'd1,
    OP_XOR  = 2'd2,
    OP_PQ   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_MALFORM = 2'd1,
    ST_LENGTH = 2'd2
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_DONE
  } fsm_e;

  typedef struct packed {
    op_e        op;
    logic [3:0] srcm1;
    logic [2:0] blk;
    logic       irq_err;
    logic       dep;
  } cmd_t;
endpackage

// File: rtl/cfdw_entry_dec.sv
module cfdw_entry_dec #(
  parameter int ADDR_W = 64
) (
  input  logic [31:0]             w0,
  input  logic [31:0]             w1,
  input  logic [31:0]             w2,
  output logic [cfdw_pkg::LEN_W-1:0] len,
  output logic                    last,
  output logic [ADDR_W-1:0]       addr
);
  logic [63:0] full_addr;
  logic        unused_bits;

  assign full_addr   = {w1, w2};
  assign addr        = full_addr[ADDR_W-1:0];
  assign len         = w0[cfdw_pkg::LEN_W-1:0];
  assign last        = w0[cfdw_pkg::LAST_BIT];
  assign unused_bits = ^{w0[31], w0[29:cfdw_pkg::LEN_W], full_addr};
endmodule

// File: rtl/cfdw_cmd_dec.sv
module cfdw_cmd_dec (
  input  logic [31:0]    word,
  output cfdw_pkg::cmd_t cmd
);
  logic unused_bits;

  always_comb begin
    cmd.op      = cfdw_pkg::op_e'(word[1:0]);
    cmd.srcm1   = word[7:4];
    cmd.blk     = word[10:8];
    cmd.irq_err = word[12];
    cmd.dep     = word[13];
  end

  assign unused_bits = ^{word[31:14], word[11], word[3:2]};
endmodule

// File: rtl/cfdw_addr_bank.sv
module cfdw_addr_bank #(
  parameter int ADDR_W = 64,
  parameter int SLOTS  = 2,
  parameter int IDX_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [ADDR_W-1:0]       wr_addr,
  output logic [SLOTS*ADDR_W-1:0] slots_flat
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))     slot_q <= wr_addr;
    end
    assign slots_flat[i*ADDR_W +: ADDR_W] = slot_q;
  end
endmodule

// File: rtl/cfdw_walker.sv
module cfdw_walker
  import cfdw_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int MAX_SRC = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_valid,
  output logic                      start_ready,
  input  logic [ADDR_W-1:0]         start_addr,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [31:0]               mem_rsp_data,
  output logic                      job_valid,
  input  logic                      job_ready,
  output logic [1:0]                job_status,
  output logic [1:0]                job_opcode,
  output logic [4:0]                job_nsrc,
  output logic [2:0]                job_blk,
  output logic                      job_irq_err,
  output logic                      job_dep,
  output logic [23:0]               job_len,
  output logic [2*ADDR_W-1:0]       job_dst_addr,
  output logic [MAX_SRC*ADDR_W-1:0] job_src_addr
);
  localparam int MAX_ENT = MAX_SRC + 3;
  localparam int ENT_W   = $clog2(MAX_ENT + 1);

  fsm_e              state;
  logic [ADDR_W-1:0] base_q, cmd_ptr_q;
  logic [ENT_W-1:0]  ent_q;
  logic [1:0]        wsel_q;
  logic [31:0]       w0_q, w1_q;
  cmd_t              cmd_q;
  logic [CNT_W-1:0]  nsrc_q;
  logic [LEN_W-1:0]  len_ref_q;
  logic              mal_q, len_err_q;

  logic [LEN_W-1:0]  e_len;
  logic              e_last;
  logic [ADDR_W-1:0] e_addr;
  cmd_t              c_dec;

  cfdw_entry_dec #(.ADDR_W(ADDR_W)) u_entry (
    .w0(w0_q), .w1(w1_q), .w2(mem_rsp_data),
    .len(e_len), .last(e_last), .addr(e_addr)
  );

  cfdw_cmd_dec u_cmd (.word(mem_rsp_data), .cmd(c_dec));

  logic             rsp_take, entry_done, cmd_done, is_dst;
  logic [ENT_W-1:0] ndst;

  assign rsp_take   = (state == S_WAIT) && mem_rsp_valid;
  assign entry_done = rsp_take && (wsel_q == 2'd2);
  assign cmd_done   = rsp_take && (wsel_q == 2'd3);
  assign ndst       = (cmd_q.op == OP_PQ) ? ENT_W'(2) : ENT_W'(1);
  assign is_dst     = (ent_q <= ndst);

  logic dst_we, src_we;
  assign dst_we = entry_done && (ent_q != '0) && is_dst;
  assign src_we = entry_done && (ent_q != '0) && !is_dst && (nsrc_q < CNT_W'(MAX_SRC));

  cfdw_addr_bank #(.ADDR_W(ADDR_W), .SLOTS(2), .IDX_W(1)) u_dst (
    .clk(clk), .rst_n(rst_n), .wr_en(dst_we), .wr_idx(~ent_q[0]),
    .wr_addr(e_addr), .slots_flat(job_dst_addr)
  );

  cfdw_addr_bank #(.ADDR_W(ADDR_W), .SLOTS(MAX_SRC), .IDX_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_en(src_we), .wr_idx(nsrc_q),
    .wr_addr(e_addr), .slots_flat(job_src_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base_q    <= '0;
      cmd_ptr_q <= '0;
      ent_q     <= '0;
      wsel_q    <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      cmd_q     <= '0;
      nsrc_q    <= '0;
      len_ref_q <= '0;
      mal_q     <= 1'b0;
      len_err_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_valid) begin
          base_q    <= start_addr;
          ent_q     <= '0;
          wsel_q    <= '0;
          nsrc_q    <= '0;
          len_ref_q <= '0;
          mal_q     <= 1'b0;
          len_err_q <= 1'b0;
          state     <= S_REQ;
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          case (wsel_q)
            2'd0: begin w0_q <= mem_rsp_data; wsel_q <= 2'd1; state <= S_REQ; end
            2'd1: begin w1_q <= mem_rsp_data; wsel_q <= 2'd2; state <= S_REQ; end
            2'd3: begin
              cmd_q <= c_dec;
              if (c_dec.op == OP_NONE) begin
                mal_q <= 1'b1;
                state <= S_DONE;
              end else begin
                ent_q  <= ENT_W'(1);
                wsel_q <= 2'd0;
                state  <= S_REQ;
              end
            end
            default: begin
              if (ent_q == '0) begin
                cmd_ptr_q <= e_addr;
                if (e_last) begin
                  mal_q <= 1'b1;
                  state <= S_DONE;
                end else begin
                  wsel_q <= 2'd3;
                  state  <= S_REQ;
                end
              end else begin
                if (ent_q == ENT_W'(1))    len_ref_q <= e_len;
                else if (e_len != len_ref_q) len_err_q <= 1'b1;
                if (e_len > LEN_W'(LEN_LIMIT)) len_err_q <= 1'b1;
                if (!is_dst) nsrc_q <= nsrc_q + CNT_W'(1);
                if (e_last) begin
                  state <= S_DONE;
                end else if (ent_q == ENT_W'(MAX_ENT - 1)) begin
                  mal_q <= 1'b1;
                  state <= S_DONE;
                end else begin
                  ent_q  <= ent_q + ENT_W'(1);
                  wsel_q <= 2'd0;
                  state  <= S_REQ;
                end
              end
            end
          endcase
        end
        S_DONE: if (job_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] want_src;
  logic             count_bad;
  assign want_src  = {1'b0, cmd_q.srcm1} + CNT_W'(1);
  assign count_bad = (nsrc_q != want_src) || (nsrc_q > CNT_W'(MAX_SRC)) ||
                     ((cmd_q.op == OP_MOVE) && (nsrc_q != CNT_W'(1)));

  assign start_ready   = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = (wsel_q == 2'd3) ? cmd_ptr_q
                                          : base_q + ADDR_W'({ent_q, wsel_q, 2'b00});
  assign job_valid     = (state == S_DONE);
  assign job_status    = (mal_q || count_bad) ? ST_MALFORM :
                         len_err_q            ? ST_LENGTH  : ST_OK;
  assign job_opcode    = cmd_q.op;
  assign job_nsrc      = nsrc_q;
  assign job_blk       = cmd_q.blk;
  assign job_irq_err   = cmd_q.irq_err;
  assign job_dep       = cmd_q.dep;
  assign job_len       = len_ref_q;

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r2_no_req_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  a_r9_job_hold: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid && $stable(job_status) &&
    $stable(job_src_addr) && $stable(job_dst_addr) && $stable(job_len));
  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> !start_ready && !mem_req_valid);
  a_r7_ok_count: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_status == ST_OK |-> job_nsrc >= 5'd1 && job_nsrc <= 5'(MAX_SRC));
  a_r7_move_single: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_status == ST_OK && job_opcode == OP_MOVE |-> job_nsrc == 5'd1);
  a_r8_ok_len: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_status == ST_OK |-> job_len <= 24'h100000);
endmodule

// File: tb/cfdw_walker_bench.sv
module cfdw_walker_bench;
  localparam int ADDR_W  = 64;
  localparam int MAXS    = 4;
  localparam int MAX_ENT = MAXS + 3;
  localparam int LIM     = 1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                   start_valid = 1'b0;
  logic                   start_ready;
  logic [ADDR_W-1:0]      start_addr = '0;
  logic                   mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0]      mem_req_addr;
  logic                   mem_rsp_valid;
  logic [31:0]            mem_rsp_data;
  logic                   job_valid;
  logic                   job_ready = 1'b0;
  logic [1:0]             job_status, job_opcode;
  logic [4:0]             job_nsrc;
  logic [2:0]             job_blk;
  logic                   job_irq_err, job_dep;
  logic [23:0]            job_len;
  logic [2*ADDR_W-1:0]    job_dst_addr;
  logic [MAXS*ADDR_W-1:0] job_src_addr;

  cfdw_walker #(.ADDR_W(ADDR_W), .MAX_SRC(MAXS)) u_cfdw_walker (.*);

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  int cyc = 0;
  logic [31:0] mem [0:1023];
  logic        pend;
  logic [ADDR_W-1:0] paddr;
  int          dly;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
      paddr         <= '0;
      dly           <= 0;
    end else begin
      mem_req_ready <= (cyc % 3) != 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend      <= 1'b1;
        paddr     <= mem_req_addr;
        dly       <= cyc % 2;
        req_count <= req_count + 1;
      end
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[paddr[11:2]];
          pend          <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ent_addr(input int cid, input int k);
    return {8'hA0, 16'(cid), 8'(k), 32'h0001_0000 + 32'(k) * 32'h40};
  endfunction

  int case_id = 0;

  task automatic run_case(input int op, input int ns, input int srcm1, input int len,
                          input int bad_idx, input int bad_len, input bit no_final);
    int ndst, total, nwrite, walked, exp_req, exp_st;
    bit mal, lerr;
    logic [1:0] st_hold;
    int wd;
    case_id++;
    ndst  = (op == 3) ? 2 : 1;
    total = 1 + ndst + ns;
    nwrite = no_final ? MAX_ENT + 1 : total;
    for (int i = 64; i < 128; i++) mem[i] = '0;
    for (int k = 0; k < nwrite; k++) begin
      logic [63:0] a;
      logic [31:0] w0;
      a  = (k == 0) ? 64'h800 : ent_addr(case_id, k);
      w0 = (k != 0 && k == bad_idx) ? 32'(bad_len) : ((k == 0) ? 32'd4 : 32'(len));
      if (!no_final && k == total - 1) w0[30] = 1'b1;
      mem[64 + 4*k]     = w0;
      mem[64 + 4*k + 1] = a[63:32];
      mem[64 + 4*k + 2] = a[31:0];
    end
    mem[512] = 32'(op) | (32'(srcm1 & 15) << 4) | (32'(case_id % 8) << 8) |
               (32'(case_id % 2) << 12) | (32'((case_id / 2) % 2) << 13);
    mal  = (op == 0) || no_final || (total > MAX_ENT) || (ns != srcm1 + 1) ||
           (ns > MAXS) || (op == 1 && ns != 1);
    lerr = (len > LIM) || (bad_idx != 0 && (bad_len != len || bad_len > LIM));
    exp_st = mal ? 1 : (lerr ? 2 : 0);
    walked = no_final ? MAX_ENT : ((total < MAX_ENT) ? total : MAX_ENT);
    exp_req = (op == 0) ? 4 : 3 * walked + 1;

    @(negedge clk);
    req_count = 0;
    start_addr  = 64'h100;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk("R1 start_ready low while busy", 64'(start_ready), 64'd0);
    wd = 0;
    while (!job_valid && wd < 2000) begin @(negedge clk); wd++; end
    chk($sformatf("R7 R8 status op=%0d ns=%0d m1=%0d", op, ns, srcm1), 64'(job_status), 64'(exp_st));
    chk("R2 R6 request count", 64'(req_count), 64'(exp_req));
    if (exp_st == 0) begin
      chk("R4 opcode", 64'(job_opcode), 64'(op));
      chk("R4 block code", 64'(job_blk), 64'(case_id % 8));
      chk("R4 irq flag", 64'(job_irq_err), 64'(case_id % 2));
      chk("R4 dep flag", 64'(job_dep), 64'((case_id / 2) % 2));
      chk("R7 source count", 64'(job_nsrc), 64'(ns));
      chk("R8 length", 64'(job_len), 64'(len));
      for (int d = 0; d < ndst; d++)
        chk("R3 R5 destination", job_dst_addr[d*ADDR_W +: ADDR_W], ent_addr(case_id, 1 + d));
      for (int s = 0; s < ns; s++)
        chk("R3 R5 source", job_src_addr[s*ADDR_W +: ADDR_W], ent_addr(case_id, 1 + ndst + s));
    end
    st_hold = job_status;
    @(negedge clk); @(negedge clk);
    chk("R9 job held", {62'd0, job_status}, {62'd0, st_hold});
    chk("R9 valid held", 64'(job_valid), 64'd1);
    job_ready = 1'b1;
    @(negedge clk);
    job_ready = 1'b0;
    chk("R9 idle after take", {62'd0, start_ready, job_valid}, 64'b10);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset start_ready", 64'(start_ready), 64'd1);
    chk("R1 reset job_valid", 64'(job_valid), 64'd0);
    chk("R1 reset req", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 1; op <= 3; op++)
      for (int ns = 0; ns <= MAXS + 1; ns++)
        for (int v = 0; v < 2; v++)
          run_case(op, ns, (v == 0) ? ((ns == 0) ? 0 : ns - 1) : ns + 1,
                   64 * (ns + 1) + 8 * op + v, 0, 0, 1'b0);
    run_case(0, 2, 1, 128, 0, 0, 1'b0);
    run_case(2, 3, 2, 256, 0, 0, 1'b1);
    run_case(3, 2, 1, 512, 0, 0, 1'b1);
    run_case(2, 2, 1, LIM, 0, 0, 1'b0);
    run_case(3, 2, 1, LIM + 1, 0, 0, 1'b0);
    run_case(2, 3, 2, 300, 4, 301, 1'b0);
    run_case(3, 1, 0, 300, 2, 299, 1'b0);
    run_case(2, 3, 0, 300, 4, 301, 1'b0);
    run_case(1, 1, 0, 64, 1, LIM + 8, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule